// File: doc/BRIEF.md
# Virtual System-Error Deferral Unit

This unit sits beside the execute stage of a core and acts when an error-synchronization barrier hint retires. It checks whether a virtual system-error exception is pending but masked. If it is, the unit does not raise the exception. It captures a syndrome into a deferred-error status register and sends a one-cycle strobe that tells the owner of the hypervisor control register to drop the virtual-error pending bit and withdraw the matching interrupt request.

The decision is a single-cycle classification into one of four named outcomes. IGNORE means the cycle is not a barrier. SKIP means the barrier acts as a no-op because of the feature straps or the exception level. KEEP means the barrier ran but nothing was pending and masked. DEFER means the error is captured. There are no transitions between these outcomes: each is picked afresh from the inputs of the current cycle. The only state kept is the status register, which is written on the clock edge that closes a DEFER cycle.

The syndrome format follows the register width of EL1. A 64-bit EL1 copies the low syndrome bits through. A 32-bit EL1 gets an asynchronous external abort fault code, in long- or short-descriptor layout, merged with three selected bits of the virtual syndrome input.

Top module: `vserr_defer_unit`

## Requirements
- R1: After reset, `defer_status` is 0 and `vse_clear` is low.
- R2: A cycle with `exec_valid` low, or with `hint_code` other than 8'h10, does not assert `vse_clear` and leaves `defer_status` unchanged.
- R3: With `has_ras` low or `is_mcu` high, the barrier hint is a no-op: no strobe and no status change.
- R4: Deferral is considered only when `cur_el` is 0 or 1 and `has_el2` is high. Otherwise the barrier is a no-op.
- R5: An error counts as pending only when `hyp_tge` is 0, `hyp_amo` is 1 and `hyp_vse` is 1. Without a pending error, nothing changes.
- R6: Deferral also requires `abort_mask` to be 1. With the mask clear, nothing changes.
- R7: On deferral with `el1_wide` high, `defer_status` becomes 32'h8000_0000 OR `vsynd[24:0]`.
- R8: On deferral with `el1_wide` low and `long_fmt` high, `defer_status` becomes 32'h8000_0011 OR (`vsynd` AND 32'h0000_D000). Fault code 6'b010001 sits in bits [5:0].
- R9: On deferral with `el1_wide` low and `long_fmt` low, `defer_status` becomes 32'h8000_0406 OR (`vsynd` AND 32'h0000_D000). Short fault code 5'b10110 has bit 4 at bit 10 and bits [3:0] at [3:0].
- R10: On a deferral cycle, `vse_clear` is high during that same cycle, and `defer_status` takes its new value with bit 31 set on the clock edge that ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_valid | input | 1 | A hint instruction is executing this cycle |
| hint_code | input | 8 | Decoded hint field |
| cur_el | input | 2 | Current exception level |
| has_el2 | input | 1 | Strap: EL2 implemented |
| has_ras | input | 1 | Strap: RAS extension supported |
| is_mcu | input | 1 | Strap: microcontroller profile |
| hyp_tge | input | 1 | Hypervisor trap-general-exceptions bit |
| hyp_amo | input | 1 | Hypervisor asynchronous-abort routing bit |
| hyp_vse | input | 1 | Virtual system-error pending bit |
| abort_mask | input | 1 | Processor-state asynchronous abort mask |
| el1_wide | input | 1 | EL1 uses the 64-bit register width |
| long_fmt | input | 1 | Long-descriptor fault format selected (32-bit EL1) |
| vsynd | input | 32 | Virtual syndrome register contents |
| defer_status | output | 32 | Deferred-error status register |
| vse_clear | output | 1 | Strobe: clear pending bit and withdraw interrupt |

## Verification
The bench drives every combination of the routing bits, the mask, the exception level, the register width and the descriptor format against a reference model. A design that mixes up the TGE or AMO polarity, ignores the mask, or lets EL2 or EL3 defer will either strobe when it must not or keep a stale status. The syndrome patterns put ones in bits above 24 and near the 0xD000 mask, so that a wrong truncation width, a misplaced short-code bit 4 or a missing AET/ExT merge all show up as a wrong status value. Hints adjacent to 8'h10, deferrable inputs with `exec_valid` low, and the profile and feature straps show whether a design decodes the barrier too loosely.

// File: rtl/vserr_pkg.sv
package vserr_pkg;

    typedef enum logic [1:0] {
        ACT_IGNORE = 2'd0,
        ACT_SKIP   = 2'd1,
        ACT_KEEP   = 2'd2,
        ACT_DEFER  = 2'd3
    } defer_act_e;

    typedef enum logic [1:0] {
        FMT_WIDE  = 2'd0,
        FMT_LONG  = 2'd1,
        FMT_SHORT = 2'd2
    } synd_fmt_e;

    localparam logic [5:0] LONG_ASYNC_EXT  = 6'b010001;
    localparam logic [4:0] SHORT_ASYNC_EXT = 5'b10110;
    localparam int unsigned SHORT_HI_POS   = 10;

endpackage

// File: rtl/vserr_qualify.sv
module vserr_qualify
    import vserr_pkg::*;
#(
    parameter int unsigned HINT_W       = 8,
    parameter int unsigned EL_W         = 2,
    parameter logic [HINT_W-1:0] BARRIER_CODE = 8'h10
) (
    input  logic              exec_valid,
    input  logic [HINT_W-1:0] hint_code,
    input  logic [EL_W-1:0]   cur_el,
    input  logic              has_el2,
    input  logic              has_ras,
    input  logic              is_mcu,
    input  logic              hyp_tge,
    input  logic              hyp_amo,
    input  logic              hyp_vse,
    input  logic              abort_mask,
    output defer_act_e        act
);

    localparam logic [EL_W-1:0] MAX_GUEST_EL = EL_W'(1);

    logic is_barrier;
    logic feature_ok;
    logic level_ok;
    logic enabled;
    logic pending;

    always_comb begin
        is_barrier = exec_valid && (hint_code == BARRIER_CODE);
        feature_ok = has_ras && !is_mcu;
        level_ok   = (cur_el <= MAX_GUEST_EL) && has_el2;
        enabled    = !hyp_tge && hyp_amo;
        pending    = enabled && hyp_vse;
    end

    always_comb begin
        if (!is_barrier) begin
            act = ACT_IGNORE;
        end else if (!feature_ok || !level_ok) begin
            act = ACT_SKIP;
        end else if (!pending || !abort_mask) begin
            act = ACT_KEEP;
        end else begin
            act = ACT_DEFER;
        end
    end

endmodule

// File: rtl/vserr_synd.sv
module vserr_synd
    import vserr_pkg::*;
#(
    parameter int unsigned SYND_W    = 32,
    parameter int unsigned WIDE_KEEP = 25,
    parameter logic [SYND_W-1:0] NARROW_MASK = 32'h0000_D000
) (
    input  logic              el1_wide,
    input  logic              long_fmt,
    input  logic [SYND_W-1:0] vsynd,
    output logic [SYND_W-1:0] synd
);

    localparam logic [SYND_W-1:0] WIDE_MASK =
        {{(SYND_W-WIDE_KEEP){1'b0}}, {WIDE_KEEP{1'b1}}};

    synd_fmt_e         fmt;
    logic [SYND_W-1:0] long_code;
    logic [SYND_W-1:0] short_code;

    always_comb begin
        long_code       = '0;
        long_code[5:0]  = LONG_ASYNC_EXT;
        short_code      = '0;
        short_code[3:0] = SHORT_ASYNC_EXT[3:0];
        short_code[SHORT_HI_POS] = SHORT_ASYNC_EXT[4];
    end

    always_comb begin
        if (el1_wide)      fmt = FMT_WIDE;
        else if (long_fmt) fmt = FMT_LONG;
        else               fmt = FMT_SHORT;
    end

    always_comb begin
        unique case (fmt)
            FMT_WIDE:  synd = vsynd & WIDE_MASK;
            FMT_LONG:  synd = long_code  | (vsynd & NARROW_MASK);
            FMT_SHORT: synd = short_code | (vsynd & NARROW_MASK);
            default:   synd = '0;
        endcase
    end

endmodule

// File: rtl/vserr_status_reg.sv
module vserr_status_reg #(
    parameter int unsigned SYND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SYND_W-1:0] wr_synd,
    output logic [SYND_W-1:0] status
);

    localparam int unsigned FLAG_POS = SYND_W - 1;

    logic [SYND_W-1:0] next_val;

    always_comb begin
        next_val           = wr_synd;
        next_val[FLAG_POS] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     status <= '0;
        else if (wr_en) status <= next_val;
    end

    // R10: a write always leaves the deferred flag set
    assert_flag_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[FLAG_POS]);

    // R2: without a write, the register holds
    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status));

endmodule

// File: rtl/vserr_defer_unit.sv
module vserr_defer_unit
    import vserr_pkg::*;
#(
    parameter int unsigned HINT_W    = 8,
    parameter int unsigned EL_W      = 2,
    parameter int unsigned SYND_W    = 32,
    parameter int unsigned WIDE_KEEP = 25,
    parameter logic [HINT_W-1:0] BARRIER_CODE = 8'h10,
    parameter logic [SYND_W-1:0] NARROW_MASK  = 32'h0000_D000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_valid,
    input  logic [7:0]        hint_code,
    input  logic [1:0]        cur_el,
    input  logic              has_el2,
    input  logic              has_ras,
    input  logic              is_mcu,
    input  logic              hyp_tge,
    input  logic              hyp_amo,
    input  logic              hyp_vse,
    input  logic              abort_mask,
    input  logic              el1_wide,
    input  logic              long_fmt,
    input  logic [31:0]       vsynd,
    output logic [31:0]       defer_status,
    output logic              vse_clear
);

    defer_act_e        act;
    logic [SYND_W-1:0] synd;
    logic              do_write;

    vserr_qualify #(
        .HINT_W       (HINT_W),
        .EL_W         (EL_W),
        .BARRIER_CODE (BARRIER_CODE)
    ) u_qualify (
        .exec_valid (exec_valid),
        .hint_code  (hint_code),
        .cur_el     (cur_el),
        .has_el2    (has_el2),
        .has_ras    (has_ras),
        .is_mcu     (is_mcu),
        .hyp_tge    (hyp_tge),
        .hyp_amo    (hyp_amo),
        .hyp_vse    (hyp_vse),
        .abort_mask (abort_mask),
        .act        (act)
    );

    vserr_synd #(
        .SYND_W      (SYND_W),
        .WIDE_KEEP   (WIDE_KEEP),
        .NARROW_MASK (NARROW_MASK)
    ) u_synd (
        .el1_wide (el1_wide),
        .long_fmt (long_fmt),
        .vsynd    (vsynd),
        .synd     (synd)
    );

    always_comb begin
        unique case (act)
            ACT_IGNORE: do_write = 1'b0;
            ACT_SKIP:   do_write = 1'b0;
            ACT_KEEP:   do_write = 1'b0;
            ACT_DEFER:  do_write = 1'b1;
            default:    do_write = 1'b0;
        endcase
        vse_clear = do_write;
    end

    vserr_status_reg #(
        .SYND_W (SYND_W)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_write),
        .wr_synd (synd),
        .status  (defer_status)
    );

    // R2: strobe only on an executing barrier hint
    assert_clear_on_barrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vse_clear |-> (exec_valid && hint_code == BARRIER_CODE));

    // R3: straps must permit the barrier
    assert_clear_needs_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vse_clear |-> (has_ras && !is_mcu));

    // R4: only guest levels with EL2 present
    assert_clear_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vse_clear |-> (cur_el <= 2'd1 && has_el2));

    // R5: a pending error is required
    assert_clear_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vse_clear |-> (!hyp_tge && hyp_amo && hyp_vse));

    // R6: the abort mask must be set
    assert_clear_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vse_clear |-> abort_mask);

    // R7: wide format syndrome after a deferral
    assert_wide_synd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vse_clear && el1_wide) |=> (defer_status == ($past(vsynd) & 32'h01FF_FFFF | 32'h8000_0000)));

endmodule

// File: tb/tb_vserr_defer_unit.sv
module tb_vserr_defer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_valid = 1'b0;
    logic [7:0]  hint_code = '0;
    logic [1:0]  cur_el = '0;
    logic        has_el2 = 1'b0, has_ras = 1'b0, is_mcu = 1'b0;
    logic        hyp_tge = 1'b0, hyp_amo = 1'b0, hyp_vse = 1'b0;
    logic        abort_mask = 1'b0, el1_wide = 1'b0, long_fmt = 1'b0;
    logic [31:0] vsynd = '0;
    logic [31:0] defer_status;
    logic        vse_clear;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] status;
        string       req;
    } exp_item_t;

    exp_item_t   sb_q[$];
    logic [31:0] model_status = '0;

    always #4 clk = ~clk;

    vserr_defer_unit dut (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .hint_code(hint_code),
        .cur_el(cur_el), .has_el2(has_el2), .has_ras(has_ras), .is_mcu(is_mcu),
        .hyp_tge(hyp_tge), .hyp_amo(hyp_amo), .hyp_vse(hyp_vse),
        .abort_mask(abort_mask), .el1_wide(el1_wide), .long_fmt(long_fmt),
        .vsynd(vsynd), .defer_status(defer_status), .vse_clear(vse_clear)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_synd(input logic wide, input logic lng, input logic [31:0] v);
        if (wide)     return 32'h8000_0000 | (v & 32'h01FF_FFFF);
        else if (lng) return 32'h8000_0011 | (v & 32'h0000_D000);
        else          return 32'h8000_0406 | (v & 32'h0000_D000);
    endfunction

    // Driver: applies one cycle of stimulus, checks the strobe, pushes the expected status
    task automatic drive(input logic ev, input logic [7:0] hc, input logic [1:0] el,
                         input logic e2, input logic ras, input logic mcu,
                         input logic tge, input logic amo, input logic vse, input logic msk,
                         input logic wide, input logic lng, input logic [31:0] v,
                         input string req);
        logic      dfr;
        exp_item_t it;
        @(negedge clk);
        exec_valid = ev; hint_code = hc; cur_el = el; has_el2 = e2; has_ras = ras;
        is_mcu = mcu; hyp_tge = tge; hyp_amo = amo; hyp_vse = vse; abort_mask = msk;
        el1_wide = wide; long_fmt = lng; vsynd = v;
        dfr = ev && (hc == 8'h10) && ras && !mcu && (el <= 2'd1) && e2
              && !tge && amo && vse && msk;
        if (dfr) model_status = ref_synd(wide, lng, v);
        it.status = model_status;
        it.req    = req;
        sb_q.push_back(it);
        #1;
        check(vse_clear === dfr, {req, " strobe (R10)"}, {31'd0, vse_clear}, {31'd0, dfr});
    endtask

    // Monitor: compares the registered status after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(defer_status === it.status, it.req, defer_status, it.status);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(defer_status === 32'h0, "R1 status", defer_status, 32'h0);
        check(vse_clear === 1'b0, "R1 strobe", {31'd0, vse_clear}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep of routing, mask, level, width and format (R4-R9)
        for (int i = 0; i < 512; i++) begin
            v = 32'hFFFF_FFFF ^ (i * 32'h9E37_79B9);
            drive(1'b1, 8'h10, i[1:0], 1'b1, 1'b1, 1'b0,
                  i[2], i[3], i[4], i[5], i[6], i[7], v,
                  i[6] ? "R7 wide" : (i[7] ? "R8 long" : "R9 short"));
        end

        // Prime a known status, then show non-barrier cycles leave it (R2)
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 0, 1, 1, 1, 1, 0, 32'hFFFF_FFFF, "R7 prime");
        drive(1'b0, 8'h10, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h1234_5678, "R2 no exec");
        drive(1'b1, 8'h00, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h1234_5678, "R2 nop");
        drive(1'b1, 8'h11, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h1234_5678, "R2 hint 11");
        drive(1'b1, 8'h90, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h1234_5678, "R2 hint 90");
        drive(1'b1, 8'h30, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h1234_5678, "R2 hint 30");

        // Straps (R3) and EL2 presence (R4)
        drive(1'b1, 8'h10, 2'd0, 1, 0, 0, 0, 1, 1, 1, 0, 1, 32'h0000_F000, "R3 no ras");
        drive(1'b1, 8'h10, 2'd1, 1, 1, 1, 0, 1, 1, 1, 0, 0, 32'h0000_F000, "R3 mcu");
        drive(1'b1, 8'h10, 2'd1, 1, 0, 1, 0, 1, 1, 1, 1, 0, 32'h0000_F000, "R3 both");
        drive(1'b1, 8'h10, 2'd0, 0, 1, 0, 0, 1, 1, 1, 0, 1, 32'h0000_F000, "R4 no el2");
        drive(1'b1, 8'h10, 2'd2, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h0000_F000, "R4 el2");
        drive(1'b1, 8'h10, 2'd3, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'h0000_F000, "R4 el3");

        // Back-to-back deferrals overwrite (R10), then format corners (R8, R9)
        drive(1'b1, 8'h10, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 32'hFFFF_FFFF, "R8 all ones");
        drive(1'b1, 8'h10, 2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 0, 32'hFFFF_FFFF, "R9 all ones");
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 32'h0000_0000, "R7 zero");
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 0, 1, 1, 1, 0, 0, 32'h0000_2FFF, "R9 outside mask");

        // Masked-off and not-pending cases after a known value (R5, R6)
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 0, 1, 1, 0, 1, 0, 32'h0ABC_DEF0, "R6 unmasked");
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 1, 1, 1, 1, 1, 0, 32'h0ABC_DEF0, "R5 tge");
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 0, 0, 1, 1, 1, 0, 32'h0ABC_DEF0, "R5 no amo");
        drive(1'b1, 8'h10, 2'd1, 1, 1, 0, 0, 1, 0, 1, 1, 0, 32'h0ABC_DEF0, "R5 no vse");
        drive(1'b0, 8'h00, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R2 idle");

        repeat (3) @(posedge clk);
        #3;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule